// File: doc/BRIEF.md
# Multi-field Alarm Match Unit

This block watches the current minute, hour, date and weekday of a calendar counter and compares them with four programmable alarm registers. Each register holds a BCD compare value and its own disable bit. A field takes part in the compare only when its disable bit is 0. When every participating field matches, the unit raises a sticky alarm flag. Software clears the flag by writing 0. An interrupt enable gates the flag onto an active-low interrupt request.

The flag is set only on a fresh match, which is a 0-to-1 change of the combined match result. If software clears the flag while the time still matches, the flag stays clear. It can set again only after the match result has dropped and then risen once more. A four-state machine tracks the flag together with the previous match result:
- `CLR_IDLE`: flag clear, no match last cycle.
- `CLR_HELD`: flag clear, match last cycle.
- `SET_HELD`: flag set, match last cycle.
- `SET_IDLE`: flag set, no match last cycle.

The transitions are:
- **rise** (`CLR_IDLE`/`SET_IDLE` to `SET_HELD` on a match): the flag sets or stays set, and this wins over a clear in the same cycle.
- **drop** (`*_HELD` to `*_IDLE` when the match ends): the flag is unchanged.
- **clear** (`SET_*` to `CLR_*` on a write of 0): the state keeps the current match result.
- **hold**: every other case, where the state is unchanged.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all four alarm registers hold 0x80 (disable bit set, value 0), `alarm_flag` is 0 and `irq_n` is 1.
- R2: A write with `alm_wr_en`=1 stores `alm_wr_data` into the register chosen by `alm_wr_sel`: 0 = minute, 1 = hour, 2 = date, 3 = weekday. Bit 7 is the disable bit. Bits [6:0] compare with the minute, bits [5:0] with the hour and date, and bits [2:0] with the weekday. Value bits above a field's width are ignored in the compare.
- R3: A field whose disable bit is 1 does not affect the match. The match is true only when at least one field is enabled and every enabled field equals its current time input.
- R4: While all four disable bits are 1, `alarm_flag` never sets, whatever the time inputs are.
- R5: When the match result goes from 0 to 1, `alarm_flag` is 1 after the next rising clock edge.
- R6: Once set, `alarm_flag` stays 1 when the match ends or the time changes, until it is cleared.
- R7: A cycle with `flag_wr_en`=1 and `flag_wr_data`=0 clears the flag at the next edge. With `flag_wr_data`=1 the flag is left unchanged.
- R8: After a clear while the match still holds, the flag stays 0 until the match drops and then rises again.
- R9: If a match rise and a clear write fall in the same cycle, the flag ends up 1.
- R10: `irq_n` is 0 exactly when `alarm_flag` is 1 and `irq_en` is 1. It follows `irq_en` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_date | input | 6 | Current date, BCD |
| cur_wday | input | 3 | Current weekday |
| alm_wr_en | input | 1 | Alarm register write strobe |
| alm_wr_sel | input | 2 | Alarm register select |
| alm_wr_data | input | 8 | Alarm register write data |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 1 | Flag write value (0 clears) |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong register or wrong previous-match state shows at `alarm_flag` one edge after the time inputs or a register write could cause a fresh match. It shows there, or as a flag that fails to set when it should. A register write takes two edges to reach the flag, so the bench compares the flag on every cycle against its own model. This catches a missed or spurious set within one cycle of the event. Random stimulus draws the time and the alarm values from small sets, so matches, drops, rises and clears that collide in the same cycle all occur often.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int NUM_FIELDS = 4;

    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_DATE = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    typedef enum logic [1:0] {
        CLR_IDLE = 2'b00,
        CLR_HELD = 2'b01,
        SET_IDLE = 2'b10,
        SET_HELD = 2'b11
    } flag_state_e;

endpackage

// File: rtl/alm_field_reg.sv
module alm_field_reg #(
    parameter int REG_W = 8,
    parameter int SEL_W = 2,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] reg_q
);
    localparam logic [REG_W-1:0] RST_VAL = {1'b1, {(REG_W-1){1'b0}}};
    localparam logic [SEL_W-1:0] MY_SEL  = SEL_W'(IDX);

    logic hit_sel;
    assign hit_sel = wr_en && (wr_sel == MY_SEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= RST_VAL;
        end else if (hit_sel) begin
            reg_q <= wr_data;
        end
    end
endmodule

// File: rtl/alm_compare.sv
module alm_compare #(
    parameter int NF    = 4,
    parameter int VAL_W = 7
) (
    input  logic [NF-1:0]            dis,
    input  logic [NF-1:0][VAL_W-1:0] val,
    input  logic [NF-1:0][VAL_W-1:0] cur,
    input  logic [NF-1:0][VAL_W-1:0] mask,
    output logic                     hit
);
    logic [NF-1:0] fld_ok;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_ok[g] = dis[g] || ((val[g] & mask[g]) == (cur[g] & mask[g]));
    end

    assign hit = (&fld_ok) && !(&dis);
endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CLR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE: state_d = hit ? SET_HELD : CLR_IDLE;
            CLR_HELD: state_d = hit ? CLR_HELD : CLR_IDLE;
            SET_HELD: begin
                if (clr) state_d = hit ? CLR_HELD : CLR_IDLE;
                else     state_d = hit ? SET_HELD : SET_IDLE;
            end
            SET_IDLE: begin
                if (hit)      state_d = SET_HELD;
                else if (clr) state_d = CLR_IDLE;
                else          state_d = SET_IDLE;
            end
            default:  state_d = CLR_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SET_IDLE, SET_HELD: flag = 1'b1;
            default:            flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int DATE_W = 6,
    parameter int WDAY_W = 3,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              alm_wr_en,
    input  logic [1:0]        alm_wr_sel,
    input  logic [REG_W-1:0]  alm_wr_data,
    input  logic              flag_wr_en,
    input  logic              flag_wr_data,
    input  logic              irq_en,
    output logic              alarm_flag,
    output logic              irq_n
);
    import alm_pkg::*;

    localparam int NF    = NUM_FIELDS;
    localparam int VAL_W = REG_W - 1;
    localparam int SEL_W = $clog2(NF);

    localparam logic [NF-1:0][VAL_W-1:0] FIELD_MASK = {
        VAL_W'((1 << WDAY_W) - 1),
        VAL_W'((1 << DATE_W) - 1),
        VAL_W'((1 << HOUR_W) - 1),
        VAL_W'((1 << MIN_W) - 1)
    };

    logic [NF-1:0][REG_W-1:0] alm_reg;
    logic [NF-1:0][VAL_W-1:0] alm_val;
    logic [NF-1:0][VAL_W-1:0] cur_vec;
    logic [NF-1:0]            field_dis;
    logic                     match_hit;
    logic                     clr_req;

    assign cur_vec[FLD_MIN]  = VAL_W'(cur_min);
    assign cur_vec[FLD_HOUR] = VAL_W'(cur_hour);
    assign cur_vec[FLD_DATE] = VAL_W'(cur_date);
    assign cur_vec[FLD_WDAY] = VAL_W'(cur_wday);

    for (genvar g = 0; g < NF; g++) begin : g_reg
        alm_field_reg #(
            .REG_W (REG_W),
            .SEL_W (SEL_W),
            .IDX   (g)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (alm_wr_en),
            .wr_sel  (alm_wr_sel),
            .wr_data (alm_wr_data),
            .reg_q   (alm_reg[g])
        );
        assign field_dis[g] = alm_reg[g][REG_W-1];
        assign alm_val[g]   = alm_reg[g][VAL_W-1:0];
    end

    alm_compare #(
        .NF    (NF),
        .VAL_W (VAL_W)
    ) u_cmp (
        .dis  (field_dis),
        .val  (alm_val),
        .cur  (cur_vec),
        .mask (FIELD_MASK),
        .hit  (match_hit)
    );

    assign clr_req = flag_wr_en && !flag_wr_data;

    alm_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (match_hit),
        .clr   (clr_req),
        .flag  (alarm_flag)
    );

    assign irq_n = !(alarm_flag && irq_en);
endmodule

// File: rtl/alm_match_checker.sv
module alm_match_checker #(
    parameter int NF = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hit,
    input logic [NF-1:0] dis_vec,
    input logic          clr_en,
    input logic          clr_val,
    input logic          flag
);
    logic prev_hit;
    logic rise;
    logic clr;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_hit <= 1'b0;
        else        prev_hit <= hit;
    end

    assign rise = hit && !prev_hit;
    assign clr  = clr_en && !clr_val;

    AST_ALL_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (&dis_vec) |-> !hit); // R4
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R6
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !rise) |=> !flag); // R7
    AST_NO_SET_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !rise) |=> !flag); // R8
    AST_RISE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && clr) |=> flag); // R9
endmodule

bind alarm_match_unit alm_match_checker #(.NF(4)) i_alm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (match_hit),
    .dis_vec (field_dis),
    .clr_en  (flag_wr_en),
    .clr_val (flag_wr_data),
    .flag    (alarm_flag)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_date = '0;
    logic [2:0] cur_wday = '0;
    logic       alm_wr_en = 1'b0;
    logic [1:0] alm_wr_sel = '0;
    logic [7:0] alm_wr_data = '0;
    logic       flag_wr_en = 1'b0;
    logic       flag_wr_data = 1'b0;
    logic       irq_en = 1'b0;
    logic       alarm_flag;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_reg [4];
    logic       m_flag;
    logic       m_prev;

    always #10 clk = ~clk;

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_wday(cur_wday), .alm_wr_en(alm_wr_en),
        .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .irq_en(irq_en), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic bit model_hit();
        bit any_on = 0;
        bit all_eq = 1;
        if (!m_reg[0][7]) begin any_on = 1; if (m_reg[0][6:0] != cur_min)  all_eq = 0; end
        if (!m_reg[1][7]) begin any_on = 1; if (m_reg[1][5:0] != cur_hour) all_eq = 0; end
        if (!m_reg[2][7]) begin any_on = 1; if (m_reg[2][5:0] != cur_date) all_eq = 0; end
        if (!m_reg[3][7]) begin any_on = 1; if (m_reg[3][2:0] != cur_wday) all_eq = 0; end
        return any_on && all_eq;
    endfunction

    task automatic check(input string req);
        logic exp_irq;
        exp_irq = !(m_flag && irq_en);
        n_cmp++;
        if (alarm_flag !== m_flag || irq_n !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
                     req, alarm_flag, irq_n, m_flag, exp_irq);
        end
    endtask

    // Called at a negedge with inputs already set; returns at the next negedge.
    task automatic step(input string req);
        bit h;
        h = model_hit();
        if (h && !m_prev)                    m_flag = 1'b1;
        else if (flag_wr_en && !flag_wr_data) m_flag = 1'b0;
        m_prev = h;
        if (alm_wr_en) m_reg[alm_wr_sel] = alm_wr_data;
        @(posedge clk);
        @(negedge clk);
        alm_wr_en  = 1'b0;
        flag_wr_en = 1'b0;
        check(req);
    endtask

    task automatic wr_alarm(input logic [1:0] sel, input logic [7:0] d, input string req);
        alm_wr_en = 1'b1; alm_wr_sel = sel; alm_wr_data = d;
        step(req);
    endtask

    task automatic wr_flag(input logic v, input string req);
        flag_wr_en = 1'b1; flag_wr_data = v;
        step(req);
    endtask

    function automatic logic [7:0] pick_val(input logic [1:0] sel, input int r);
        case (sel)
            2'd0:    return (r % 3 == 0) ? 8'h00 : (r % 3 == 1) ? 8'h30 : 8'h59;
            2'd1:    return (r % 3 == 0) ? 8'h00 : (r % 3 == 1) ? 8'h12 : 8'h23;
            2'd2:    return (r % 2 == 0) ? 8'h01 : 8'h15;
            default: return (r % 2 == 0) ? 8'h00 : 8'h03;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h80;
        m_flag = 1'b0;
        m_prev = 1'b0;
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;

        // R4: all fields disabled, time sweeps through values
        for (int k = 0; k < 8; k++) begin
            cur_min = 7'(k * 7); cur_hour = 6'(k); cur_date = 6'(k + 1); cur_wday = 3'(k);
            step("R4 all disabled");
        end
        cur_min = 7'h30; cur_hour = 6'h12; cur_date = 6'h15; cur_wday = 3'd3;
        step("R4 all disabled steady");

        // R3 R5: enable minute only, matching -> rise sets flag (two edges after write)
        wr_alarm(2'd0, 8'h30, "R2 R5 minute write");
        step("R5 rise sets flag");
        cur_hour = 6'h05;
        step("R3 disabled hour ignored");
        // R6: match drops, flag sticky
        cur_min = 7'h31;
        step("R6 sticky on drop");
        // R7: writing 1 leaves flag
        wr_flag(1'b1, "R7 write one no effect");
        // R10: irq gating
        irq_en = 1'b0; #1;
        check("R10 irq masked");
        irq_en = 1'b1; #1;
        check("R10 irq active");
        // R7: clear
        wr_flag(1'b0, "R7 clear");
        // R8: rematch, then clear while matching, stays clear
        cur_min = 7'h30;
        step("R5 rematch sets");
        wr_flag(1'b0, "R8 clear during match");
        step("R8 no reset while held");
        step("R8 still clear");
        cur_min = 7'h00;
        step("R8 drop");
        cur_min = 7'h30;
        step("R8 rise again sets");
        // R9: rise and clear together
        cur_min = 7'h00;
        step("R9 drop");
        cur_min = 7'h30; flag_wr_en = 1'b1; flag_wr_data = 1'b0;
        step("R9 rise beats clear");
        wr_flag(1'b0, "R7 clear again");
        // R2: hour field with bit 6 set, upper bit ignored
        wr_alarm(2'd1, 8'h52, "R2 hour write");
        cur_hour = 6'h12; cur_min = 7'h00;
        step("R2 minute mismatch");
        cur_min = 7'h30;
        step("R2 upper value bit ignored");
        wr_flag(1'b0, "R7 clear");
        // R3: re-disable minute, hour-only alarm
        wr_alarm(2'd0, 8'hB0, "R3 disable minute");
        cur_hour = 6'h13;
        step("R3 hour mismatch drop");
        cur_hour = 6'h12; cur_min = 7'h11;
        step("R3 minute ignored hour rise");
        // R2: weekday select
        wr_flag(1'b0, "R7 clear");
        wr_alarm(2'd3, 8'h03, "R2 weekday write");
        cur_wday = 3'd4;
        step("R3 weekday mismatch");
        cur_wday = 3'd3;
        step("R2 weekday rise");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 1000);
            cur_min  = 7'(pick_val(2'd0, int'($urandom % 97)));
            if (r % 3 == 0) cur_hour = 6'(pick_val(2'd1, int'($urandom % 97)));
            if (r % 5 == 0) cur_date = 6'(pick_val(2'd2, int'($urandom % 97)));
            if (r % 7 == 0) cur_wday = 3'(pick_val(2'd3, int'($urandom % 97)));
            if ($urandom % 10 == 0) begin
                alm_wr_en  = 1'b1;
                alm_wr_sel = 2'($urandom % 4);
                alm_wr_data = pick_val(alm_wr_sel, int'($urandom % 97))
                            | ((($urandom % 3) == 0) ? 8'h80 : 8'h00);
            end
            if ($urandom % 8 == 0) begin
                flag_wr_en = 1'b1;
                flag_wr_data = 1'($urandom % 2);
            end
            if ($urandom % 16 == 0) irq_en = ~irq_en;
            step("R3 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule